// File: doc/BRIEF.md
# Output-Disable Request Input Controller

This block watches four active-low shutdown request pins and turns a qualifying request on any of them into a sticky flag. Downstream logic uses that flag to tri-state timer outputs. Each pin has its own 2-bit mode. The mode picks one of two detection methods. The first accepts a falling edge. The second accepts a low level, but only after sixteen consecutive samples are all low. Those samples are taken at the system clock divided by 8, 16 or 128.

Software reaches one 16-bit control/status word through a synchronous register port with read and write strobes. A flag can only be removed by a two-step handshake:
1. Software reads the word and sees the flag as 1.
2. Software then writes 0 to that flag.

While any flag is set, the block drives a high-impedance request. If the enable bit is on, it also raises an interrupt.

Each flag is held by a small state machine with three states:
- **FL_IDLE**: no request.
- **FL_SET**: a request is latched but has not yet been read.
- **FL_ARMED**: the request is latched and has been read as 1.

The transitions are:
- **idle-to-set**: on a request.
- **set-to-armed**: on a read without a write.
- **armed-to-idle**: on a write of 0 with no request in the same cycle.
- **armed-to-set**: on any other write.

A write has precedence over a read that arrives in the same cycle.

Top module: `odr_ctrl`

## Requirements
- R1: After reset the register reads 16'h0000, and `irq` and `hiz_req` are 0.
- R2: Bit 8 is the interrupt enable. Bits [2i+1:2i] hold pin i's mode. All of these are written by a write strobe and read back unchanged.
- R3: In mode 00, a falling edge on a pin sets its flag. The flag is visible three clock edges after the pin changes: two synchronizer stages, then the edge register. A pin that stays low causes no further sets.
- R4: In mode 01, a flag sets only after 16 consecutive low samples taken every 8 clocks.
- R5: Mode 10 uses the same 16-sample rule with a sample every 16 clocks.
- R6: Mode 11 uses the same 16-sample rule with a sample every 128 clocks.
- R7: In a filter mode, a high sample restarts the sample count.
- R8: Pin i's flag reads at bit 12+i. It clears only on a write of 0 that follows a read returning it as 1. A write of 0 without such a read, or a write of 1, leaves it set.
- R9: Bits 11:9 always read 0, whatever is written.
- R10: `irq` is 1 exactly when the enable bit is 1 and at least one flag is set.
- R11: `hiz_req` is 1 exactly when at least one flag is set, and it stays 1 until the flags are cleared.
- R12: A request in the same cycle as a valid clearing write keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 4 | Active-low shutdown request pins, asynchronous |
| reg_rd | input | 1 | Read strobe; arms every flag that reads as 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Control/status word |
| irq | output | 1 | Interrupt request |
| hiz_req | output | 1 | High-impedance request to timer outputs |

## Verification
Register writes and clears take effect on the clock edge that ends the strobe cycle. A pin edge shows up in its flag on the third edge after the pin changes. A filtered request lands between 15 and 16 sample periods after the first low sample, plus the synchronizer delay.

The bench updates a behavioural model at each rising edge and compares every output 2 ns later, so each result is checked in exactly the cycle it is due. The directed checks for the filter modes sample a little before the earliest possible set and a little after the latest possible set, so they hold across every prescaler phase.

// File: rtl/odr_pkg.sv
package odr_pkg;
    localparam int NPIN = 4;
    localparam int FLAG_LSB = 12;

    typedef enum logic [1:0] {
        MD_EDGE  = 2'b00,
        MD_DIV_A = 2'b01,
        MD_DIV_B = 2'b10,
        MD_DIV_C = 2'b11
    } det_mode_e;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'b00,
        FL_SET   = 2'b01,
        FL_ARMED = 2'b10
    } flag_state_e;
endpackage

// File: rtl/odr_prescale.sv
module odr_prescale #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] tick
);
    localparam int PW = $clog2(DIV_C);
    localparam int WA = $clog2(DIV_A);
    localparam int WB = $clog2(DIV_B);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        tick[0] = &cnt_q[WA-1:0];
        tick[1] = &cnt_q[WB-1:0];
        tick[2] = &cnt_q;
    end

    AST_SLOW_TICK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        tick[2] |-> (tick[1] && tick[0])); // R6
    AST_TICK_A_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        tick[0] |=> !tick[0]); // R4
endmodule

// File: rtl/odr_pin_filter.sv
module odr_pin_filter
    import odr_pkg::*;
#(
    parameter int SAMPLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  det_mode_e  mode,
    input  logic [2:0] tick,
    output logic       req
);
    localparam int CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] FULL = CW'(SAMPLES);

    logic          sy1_q, sy2_q, sy3_q;
    logic [CW-1:0] cnt_q;
    logic          tick_sel;
    logic          fall;
    logic          full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy1_q <= 1'b1;
            sy2_q <= 1'b1;
            sy3_q <= 1'b1;
        end else begin
            sy1_q <= pin_n;
            sy2_q <= sy1_q;
            sy3_q <= sy2_q;
        end
    end

    always_comb begin
        unique case (mode)
            MD_EDGE:  tick_sel = 1'b0;
            MD_DIV_A: tick_sel = tick[0];
            MD_DIV_B: tick_sel = tick[1];
            MD_DIV_C: tick_sel = tick[2];
            default:  tick_sel = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (mode == MD_EDGE)  cnt_q <= '0;
        else if (tick_sel) begin
            if (sy2_q)             cnt_q <= '0;
            else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        fall = sy3_q & ~sy2_q;
        full = (cnt_q == FULL);
        req  = (mode == MD_EDGE) ? fall : full;
    end

    AST_HIGH_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_sel && sy2_q) |=> (cnt_q == '0)); // R7
    AST_COUNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_sel && mode != MD_EDGE) |=> $stable(cnt_q)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R5
endmodule

// File: rtl/odr_flag_cell.sv
module odr_flag_cell
    import odr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic rd,
    input  logic wr,
    input  logic wbit,
    output logic flag
);
    flag_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_IDLE:  st_d = set ? FL_SET : FL_IDLE;
            FL_SET:   st_d = (rd && !wr) ? FL_ARMED : FL_SET;
            FL_ARMED: begin
                if (wr) st_d = (!wbit && !set) ? FL_IDLE : FL_SET;
                else    st_d = FL_ARMED;
            end
            default:  st_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag = (st_q != FL_IDLE);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag); // R12
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && st_q != FL_ARMED) |=> flag); // R8
    AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr && wbit) |=> flag); // R8
endmodule

// File: rtl/odr_ctrl.sv
module odr_ctrl
    import odr_pkg::*;
#(
    parameter int SAMPLES = 16,
    parameter int DIV_A   = 8,
    parameter int DIV_B   = 16,
    parameter int DIV_C   = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  req_n,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        hiz_req
);
    localparam int CTRL_W = 2 * NPIN + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [2:0]        tick;
    logic [NPIN-1:0]   req;
    logic [NPIN-1:0]   flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (reg_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end

    odr_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        odr_pin_filter #(.SAMPLES(SAMPLES)) u_filt (
            .clk(clk), .rst_n(rst_n), .pin_n(req_n[i]),
            .mode(det_mode_e'(ctrl_q[2*i+1 -: 2])), .tick(tick), .req(req[i])
        );
        odr_flag_cell u_flag (
            .clk(clk), .rst_n(rst_n), .set(req[i]), .rd(reg_rd), .wr(reg_wr),
            .wbit(reg_wdata[FLAG_LSB+i]), .flag(flag[i])
        );
    end

    always_comb begin
        reg_rdata = {flag, 3'b000, ctrl_q};
        hiz_req   = |flag;
        irq       = ctrl_q[CTRL_W-1] & hiz_req;
    end

    AST_HIZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_req && !reg_wr) |=> hiz_req); // R11
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[11:9] != 3'b000) |=> (reg_rdata[11:9] == 3'b000)); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (reg_rdata[15:12] != 4'h0)); // R10
endmodule

// File: tb/tb_odr_ctrl.sv
module tb_odr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_n = 4'hF;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq, hiz_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    odr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .hiz_req(hiz_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [3:0] hq[$];
    bit  m_flag[4];
    bit  m_arm[4];
    int  m_cnt[4];
    int  m_mode[4];
    bit  m_ie;
    int  m_pre;

    function automatic int period(input int md);
        return (md == 1) ? 8 : (md == 2) ? 16 : 128;
    endfunction

    task automatic model_step();
        bit setv[4];
        bit old_flag[4];
        logic [3:0] smp = req_n;
        if (!rst_n) begin
            hq = '{4'hF, 4'hF, 4'hF};
            for (int i = 0; i < 4; i++) begin
                m_flag[i] = 0; m_arm[i] = 0; m_cnt[i] = 0; m_mode[i] = 0;
            end
            m_ie = 0; m_pre = 0;
            return;
        end
        for (int i = 0; i < 4; i++) begin
            old_flag[i] = m_flag[i];
            if (m_mode[i] == 0) setv[i] = hq[2][i] && !hq[1][i];
            else                setv[i] = (m_cnt[i] == 16);
            if (m_mode[i] == 0) m_cnt[i] = 0;
            else if ((m_pre % period(m_mode[i])) == period(m_mode[i]) - 1) begin
                if (hq[1][i]) m_cnt[i] = 0;
                else if (m_cnt[i] < 16) m_cnt[i]++;
            end
            if (reg_wr) begin
                if (m_flag[i] && m_arm[i] && !reg_wdata[12+i] && !setv[i]) m_flag[i] = 0;
                else m_flag[i] = m_flag[i] | setv[i];
                m_arm[i] = 0;
            end else if (reg_rd) begin
                m_arm[i] = old_flag[i];
                m_flag[i] = m_flag[i] | setv[i];
            end else begin
                m_flag[i] = m_flag[i] | setv[i];
            end
        end
        if (reg_wr) begin
            m_ie = reg_wdata[8];
            for (int i = 0; i < 4; i++) m_mode[i] = int'(reg_wdata[2*i +: 2]);
        end
        m_pre = (m_pre + 1) % 128;
        hq.push_front(smp);
        void'(hq.pop_back());
    endtask

    always @(posedge clk) begin
        logic [3:0] ef;
        logic [7:0] em;
        model_step();
        #2;
        if (rst_n) begin
            ef = {m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
            for (int i = 0; i < 4; i++) em[2*i +: 2] = 2'(m_mode[i]);
            chk("R8 flags", 32'(reg_rdata[15:12]), 32'(ef));
            chk("R9 reserved", 32'(reg_rdata[11:9]), 32'h0);
            chk("R2 ctrl", 32'(reg_rdata[8:0]), 32'({m_ie, em}));
            chk("R10 irq", 32'(irq), 32'(m_ie && (ef != 0)));
            chk("R11 hiz", 32'(hiz_req), 32'(ef != 0));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(5);
        chk("R1 rdata", 32'(reg_rdata), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 hiz", 32'(hiz_req), 32'h0);
        rst_n = 1'b1;
        cyc(3);
        // R2 / R9 / R8: all-ones write, flags must stay 0
        wr(16'hFFFF);
        chk("R9 all-ones readback", 32'(reg_rdata), 32'h01FF);
        wr(16'h00E4);
        chk("R2 modes readback", 32'(reg_rdata), 32'h00E4);
        // R3 edge on pin 0
        @(negedge clk); req_n[0] = 1'b0;
        cyc(2);
        chk("R3 not yet", 32'(reg_rdata[12]), 32'h0);
        cyc(1);
        chk("R3 edge sets", 32'(reg_rdata[12]), 32'h1);
        chk("R11 hiz on", 32'(hiz_req), 32'h1);
        chk("R10 irq off when disabled", 32'(irq), 32'h0);
        wr(16'h01E4);
        chk("R10 irq on", 32'(irq), 32'h1);
        chk("R8 write0 without read keeps", 32'(reg_rdata[12]), 32'h1);
        rd();
        wr(16'h11E4);
        chk("R8 write1 keeps", 32'(reg_rdata[12]), 32'h1);
        rd();
        wr(16'h01E4);
        chk("R8 cleared", 32'(reg_rdata[12]), 32'h0);
        chk("R11 hiz off", 32'(hiz_req), 32'h0);
        cyc(20);
        chk("R3 held low no reset", 32'(reg_rdata[12]), 32'h0);
        req_n[0] = 1'b1;
        // R4 pin 1, divide by 8
        req_n[1] = 1'b0;
        cyc(100);
        chk("R4 early", 32'(reg_rdata[13]), 32'h0);
        cyc(60);
        chk("R4 set", 32'(reg_rdata[13]), 32'h1);
        rd();
        wr(16'h01E4);
        chk("R12 set wins", 32'(reg_rdata[13]), 32'h1);
        req_n[1] = 1'b1;
        cyc(20);
        rd();
        wr(16'h01E4);
        chk("R8 clear after release", 32'(reg_rdata[13]), 32'h0);
        // R7 restart
        req_n[1] = 1'b0; cyc(100);
        req_n[1] = 1'b1; cyc(16);
        req_n[1] = 1'b0; cyc(100);
        chk("R7 restarted", 32'(reg_rdata[13]), 32'h0);
        cyc(60);
        chk("R7 set after full run", 32'(reg_rdata[13]), 32'h1);
        req_n[1] = 1'b1; cyc(20);
        rd(); wr(16'h01E4);
        chk("R7 cleared", 32'(reg_rdata[13]), 32'h0);
        // R5 pin 2, divide by 16
        req_n[2] = 1'b0;
        cyc(200);
        chk("R5 early", 32'(reg_rdata[14]), 32'h0);
        cyc(90);
        chk("R5 set", 32'(reg_rdata[14]), 32'h1);
        req_n[2] = 1'b1;
        // R6 pin 3, divide by 128
        req_n[3] = 1'b0;
        cyc(1800);
        chk("R6 early", 32'(reg_rdata[15]), 32'h0);
        cyc(300);
        chk("R6 set", 32'(reg_rdata[15]), 32'h1);
        req_n[3] = 1'b1;
        cyc(10);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule